// File: doc/BRIEF.md
# Queued SPI Master

This block is an SPI master that works through a queue of up to sixteen serial transfers on its own once software has started it. Three sixteen-entry word stores sit inside it: one for outgoing data, one for incoming data and one holding a small command word per entry. Software reaches all three through a single pointer register and a single data window on a 16-bit register bus. Each access through the window moves the pointer on by one.

When started, the block walks the entries from a programmable start index to a programmable end index. The index wraps modulo sixteen. Each word is shifted out MSB first, with the chosen clock polarity, clock phase, word length and clock divider. The word clocked in at the same time is stored in the matching receive entry. After the end entry the run bit clears and a finish flag rises, which can drive an interrupt. A running queue can also be looped, paused between entries, or cut short. A write that would disturb the entry being shifted is refused and flagged.

Top module: `qspi_queue_master`

## Requirements
- R1: After reset, the mode, run and status registers read 0, the queue-control register reads 0x1000, the RAM pointer reads 0, `irq` is 0, `sck` is 0 and `cs_out` is 1.
- R2: Register offsets: mode 0x00, run 0x04, queue control 0x08, status 0x0C, RAM pointer 0x10, RAM data 0x14. The pointer (6 bits) selects transmit entries at 0x00–0x0F, receive entries at 0x10–0x1F and command entries at 0x20–0x2F. Every read or write at 0x14 advances the pointer by one. Receive entries cannot be written from the bus.
- R3: Mode bit 15 enables the master and bits 7:0 hold the divider D. Each half period of `sck` lasts D system clocks, and D = 1 behaves as 2.
- R4: Mode bit 9 (polarity) is the idle level of `sck`. With mode bit 8 (phase) at 0, data is sampled on the leading edge and changed on the trailing edge; with it at 1, data is changed on the leading edge and sampled on the trailing edge. Bits go MSB first, and a received word is stored right-justified.
- R5: Command bit 14 set selects the word length from mode bits 13:10 (0 means 16, 8 to 15 mean themselves). Clear, it selects 8 bits.
- R6: Writing 1 to run-register bit 15 starts the queue at queue-control bits 3:0, and bit 15 then reads 1. It clears by itself after the entry at queue-control bits 11:8 completes. The write is ignored when mode bit 15 is 0 or the divider is 0.
- R7: After index 15 the entry index continues at 0. With queue-control bit 14 set, the queue restarts at the start index after the end entry and keeps running.
- R8: `cs_out` takes the inverse of queue-control bit 12 while an entry shifts, and the value of bit 12 while idle. Between entries it stays active when the finished entry has command bit 15 set; otherwise it goes inactive for one half period.
- R9: Status bit 0 sets when a queue finishes. `irq` equals bit 0 AND status bit 8 (the enable, written directly). Writing 1 to bit 0 clears it.
- R10: Writing 0 to run-register bit 15 during a run stops the queue after the current entry. Status bit 2 then sets and bit 0 does not; writing 1 to bit 2 clears it.
- R11: While running, a RAM data write whose pointer index equals the active entry index is dropped, and status bit 3 sets; writing 1 to bit 3 clears it.
- R12: While queue-control bit 15 is set, the queue waits after the current entry with the run bit still 1, and it continues once the bit is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_en | input | 1 | Register access strobe, one cycle per access |
| reg_wr | input | 1 | 1 for write, 0 for read |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Queue-finished interrupt |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_out | output | 1 | Chip select |

## Verification
Read data is combinational and is sampled in the access cycle itself. A register write takes effect at that clock edge, so run, status and `irq` are checked on the falling edge right after it. Serial results have no fixed latency against the bus, so the bench polls the run bit until it reads 0 before comparing captured and received words. The `sck` half period is timed between the first two edges of a word and must equal the divider times the 4 ns clock.

// File: rtl/qspi_pkg.sv
package qspi_pkg;
    localparam logic [4:0] OFS_MODE = 5'h00;
    localparam logic [4:0] OFS_RUN  = 5'h04;
    localparam logic [4:0] OFS_QCTL = 5'h08;
    localparam logic [4:0] OFS_STAT = 5'h0C;
    localparam logic [4:0] OFS_PTR  = 5'h10;
    localparam logic [4:0] OFS_DATA = 5'h14;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_LOAD,
        SQ_SHIFT,
        SQ_GAP
    } seq_state_e;
endpackage

// File: rtl/qspi_ram.sv
module qspi_ram #(
    parameter int DEPTH = 16,
    parameter int W     = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [W-1:0]  rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [W-1:0]  rdata_b
);
    logic [W-1:0] mem_d [DEPTH];
    logic [W-1:0] mem_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) mem_d[i] = mem_q[i];
        if (we) mem_d[waddr] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
        end
    end

    assign rdata_a = mem_q[raddr_a];
    assign rdata_b = mem_q[raddr_b];
endmodule

// File: rtl/qspi_shift.sv
module qspi_shift #(
    parameter int W  = 16,
    parameter int CW = 8,
    localparam int NW = $clog2(W) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [W-1:0]  tx_word,
    input  logic [NW-1:0] nbits,
    input  logic          cpol,
    input  logic          cpha,
    input  logic [CW-1:0] half_div,
    input  logic          miso,
    output logic          busy,
    output logic          done,
    output logic [W-1:0]  rx_word,
    output logic          sck,
    output logic          mosi
);
    localparam logic [NW:0] W_L = (NW+1)'(W);

    typedef struct packed {
        logic          busy;
        logic          done;
        logic [CW-1:0] cnt;
        logic [NW:0]   half;
        logic [NW:0]   last;
        logic          sclk;
        logic [W-1:0]  txs;
        logic [W-1:0]  rxs;
    } shift_t;

    shift_t s_d, s_q;
    logic   lead;
    logic [NW:0] sh_amt;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        lead     = ~s_q.half[0];
        sh_amt   = W_L - {1'b0, nbits};
        if (!s_q.busy) begin
            if (start) begin
                s_d.busy = 1'b1;
                s_d.cnt  = '0;
                s_d.half = '0;
                s_d.sclk = cpol;
                s_d.txs  = tx_word << sh_amt;
                s_d.rxs  = '0;
                s_d.last = {nbits, 1'b0} - (NW+1)'(1);
            end
        end else if (s_q.cnt == half_div - CW'(1)) begin
            s_d.cnt  = '0;
            s_d.sclk = ~s_q.sclk;
            if (lead ^ cpha) s_d.rxs = {s_q.rxs[W-2:0], miso};
            if (cpha ? (lead && s_q.half != '0) : !lead) s_d.txs = s_q.txs << 1;
            if (s_q.half == s_q.last) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
            end else begin
                s_d.half = s_q.half + (NW+1)'(1);
            end
        end else begin
            s_d.cnt = s_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy    = s_q.busy;
    assign done    = s_q.done;
    assign rx_word = s_q.rxs;
    assign sck     = s_q.busy ? s_q.sclk : cpol;
    assign mosi    = s_q.txs[W-1];

    // R4: an even number of edges brings the clock back to its idle level
    a_r4_idle_level_after_word: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.done |-> (s_q.sclk == cpol));

    // R3: no clock edge while a half period is still being counted
    a_r3_hold_within_half: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && s_q.cnt != '0) |-> $stable(s_q.sclk));

    // R5: the edge index never runs past the word length
    a_r5_half_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.busy |-> (s_q.half <= s_q.last));
endmodule

// File: rtl/qspi_seq.sv
module qspi_seq
    import qspi_pkg::*;
#(
    parameter int IW = 4,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic          stop_req,
    input  logic          halt,
    input  logic          wrap_en,
    input  logic [IW-1:0] start_ptr,
    input  logic [IW-1:0] end_ptr,
    input  logic          keep_cs,
    input  logic [CW-1:0] half_div,
    input  logic          shift_done,
    output logic          running,
    output logic [IW-1:0] ptr,
    output logic          shift_start,
    output logic          cs_active,
    output logic          rx_we,
    output logic          finished,
    output logic          aborted
);
    typedef struct packed {
        seq_state_e    state;
        logic [IW-1:0] ptr;
        logic          abort_pend;
        logic          cs;
        logic [CW-1:0] cnt;
    } seq_t;

    seq_t q_d, q_q;

    always_comb begin
        q_d         = q_q;
        shift_start = 1'b0;
        rx_we       = 1'b0;
        finished    = 1'b0;
        aborted     = 1'b0;
        if (stop_req) q_d.abort_pend = 1'b1;
        case (q_q.state)
            SQ_IDLE: begin
                if (go) begin
                    q_d.ptr        = start_ptr;
                    q_d.state      = SQ_LOAD;
                    q_d.cs         = 1'b1;
                    q_d.abort_pend = 1'b0;
                end
            end
            SQ_LOAD: begin
                shift_start = 1'b1;
                q_d.state   = SQ_SHIFT;
            end
            SQ_SHIFT: begin
                if (shift_done) begin
                    rx_we = 1'b1;
                    if (q_q.abort_pend || stop_req) begin
                        q_d.state      = SQ_IDLE;
                        q_d.cs         = 1'b0;
                        q_d.abort_pend = 1'b0;
                        aborted        = 1'b1;
                    end else if (q_q.ptr == end_ptr && !wrap_en) begin
                        q_d.state = SQ_IDLE;
                        q_d.cs    = 1'b0;
                        finished  = 1'b1;
                    end else begin
                        q_d.ptr   = (q_q.ptr == end_ptr) ? start_ptr : q_q.ptr + IW'(1);
                        q_d.cs    = keep_cs;
                        q_d.cnt   = '0;
                        q_d.state = SQ_GAP;
                    end
                end
            end
            SQ_GAP: begin
                if (q_q.abort_pend || stop_req) begin
                    q_d.state      = SQ_IDLE;
                    q_d.cs         = 1'b0;
                    q_d.abort_pend = 1'b0;
                    aborted        = 1'b1;
                end else if (q_q.cnt == half_div - CW'(1)) begin
                    if (!halt) begin
                        q_d.state = SQ_LOAD;
                        q_d.cs    = 1'b1;
                    end
                end else begin
                    q_d.cnt = q_q.cnt + CW'(1);
                end
            end
            default: q_d.state = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '{state: SQ_IDLE, default: '0};
        else        q_q <= q_d;
    end

    assign running   = (q_q.state != SQ_IDLE);
    assign ptr       = q_q.ptr;
    assign cs_active = q_q.cs;

    // R8: the select is active for the whole of every shifted entry
    a_r8_cs_while_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (q_q.state == SQ_SHIFT) |-> q_q.cs);

    // R6: a queue ends only on its end entry
    a_r6_finish_on_end: assert property (@(posedge clk) disable iff (!rst_n)
        finished |-> (q_q.ptr == end_ptr));
endmodule

// File: rtl/qspi_queue_master.sv
module qspi_queue_master
    import qspi_pkg::*;
#(
    parameter int QDEPTH = 16,
    parameter int DIVW   = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_en,
    input  logic        reg_wr,
    input  logic [4:0]  reg_addr,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    output logic        irq,
    output logic        sck,
    output logic        mosi,
    input  logic        miso,
    output logic        cs_out
);
    localparam int W    = 16;
    localparam int IW   = $clog2(QDEPTH);
    localparam int NW   = $clog2(W) + 1;
    localparam int PW   = IW + 2;
    localparam int NRAM = 3;

    typedef struct packed {
        logic [15:0]   mode;
        logic [15:0]   qctl;
        logic          ien;
        logic          fin;
        logic          abrt;
        logic          wcol;
        logic [PW-1:0] aptr;
    } regs_t;

    regs_t r_d, r_q;

    logic          seq_running, seq_start, seq_cs, seq_rx_we, seq_fin, seq_abort;
    logic [IW-1:0] seq_ptr;
    logic          sh_busy, sh_done;
    logic [W-1:0]  sh_rx;
    logic [DIVW-1:0] half_div;
    logic [NW-1:0] nbits;
    logic          go, stop_req, collide, wr_acc, data_acc;
    logic [1:0]    region;
    logic [IW-1:0] aidx;

    logic          ram_we    [NRAM];
    logic [IW-1:0] ram_waddr [NRAM];
    logic [W-1:0]  ram_wdata [NRAM];
    logic [W-1:0]  ram_rd_a  [NRAM];
    logic [W-1:0]  ram_rd_b  [NRAM];

    // index 0: transmit, 1: receive, 2: command
    assign region   = r_q.aptr[PW-1:PW-2];
    assign aidx     = r_q.aptr[IW-1:0];
    assign wr_acc   = reg_en && reg_wr;
    assign data_acc = reg_en && (reg_addr == OFS_DATA);
    assign collide  = wr_acc && data_acc && seq_running && (aidx == seq_ptr) && (region != 2'd3);

    assign ram_we[0]    = wr_acc && data_acc && (region == 2'd0) && !collide;
    assign ram_we[1]    = seq_rx_we;
    assign ram_we[2]    = wr_acc && data_acc && (region == 2'd2) && !collide;
    assign ram_waddr[0] = aidx;
    assign ram_waddr[1] = seq_ptr;
    assign ram_waddr[2] = aidx;
    assign ram_wdata[0] = reg_wdata;
    assign ram_wdata[1] = sh_rx;
    assign ram_wdata[2] = reg_wdata;

    for (genvar k = 0; k < NRAM; k++) begin : g_ram
        qspi_ram #(.DEPTH(QDEPTH), .W(W)) u_ram (
            .clk     (clk),
            .rst_n   (rst_n),
            .we      (ram_we[k]),
            .waddr   (ram_waddr[k]),
            .wdata   (ram_wdata[k]),
            .raddr_a (aidx),
            .rdata_a (ram_rd_a[k]),
            .raddr_b (seq_ptr),
            .rdata_b (ram_rd_b[k])
        );
    end

    assign go = wr_acc && (reg_addr == OFS_RUN) && reg_wdata[15] && !seq_running
                && r_q.mode[15] && (r_q.mode[DIVW-1:0] != '0);
    assign stop_req = wr_acc && (reg_addr == OFS_RUN) && !reg_wdata[15] && seq_running;

    always_comb begin
        half_div = (r_q.mode[DIVW-1:0] == DIVW'(1)) ? DIVW'(2) : r_q.mode[DIVW-1:0];
        if (!ram_rd_b[2][14])                  nbits = NW'(8);
        else if (r_q.mode[13:10] == 4'd0)      nbits = NW'(16);
        else if (r_q.mode[13:10] < 4'd8)       nbits = NW'(8);
        else                                   nbits = NW'(r_q.mode[13:10]);
    end

    always_comb begin
        r_d = r_q;
        if (wr_acc) begin
            case (reg_addr)
                OFS_MODE: r_d.mode = reg_wdata;
                OFS_QCTL: r_d.qctl = reg_wdata;
                OFS_PTR:  r_d.aptr = reg_wdata[PW-1:0];
                OFS_STAT: begin
                    r_d.ien = reg_wdata[8];
                    if (reg_wdata[0]) r_d.fin  = 1'b0;
                    if (reg_wdata[2]) r_d.abrt = 1'b0;
                    if (reg_wdata[3]) r_d.wcol = 1'b0;
                end
                default: ;
            endcase
        end
        if (data_acc) r_d.aptr = r_q.aptr + PW'(1);
        if (seq_fin)   r_d.fin  = 1'b1;
        if (seq_abort) r_d.abrt = 1'b1;
        if (collide)   r_d.wcol = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{qctl: 16'h1000, default: '0};
        else        r_q <= r_d;
    end

    always_comb begin
        case (reg_addr)
            OFS_MODE: reg_rdata = r_q.mode;
            OFS_RUN:  reg_rdata = {seq_running, 15'd0};
            OFS_QCTL: reg_rdata = r_q.qctl;
            OFS_STAT: reg_rdata = {7'd0, r_q.ien, 4'd0, r_q.wcol, r_q.abrt, 1'b0, r_q.fin};
            OFS_PTR:  reg_rdata = 16'(r_q.aptr);
            OFS_DATA: reg_rdata = (region == 2'd3) ? 16'd0 : ram_rd_a[region];
            default:  reg_rdata = 16'd0;
        endcase
    end

    qspi_seq #(.IW(IW), .CW(DIVW)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .go          (go),
        .stop_req    (stop_req),
        .halt        (r_q.qctl[15]),
        .wrap_en     (r_q.qctl[14]),
        .start_ptr   (r_q.qctl[IW-1:0]),
        .end_ptr     (r_q.qctl[8+IW-1:8]),
        .keep_cs     (ram_rd_b[2][15]),
        .half_div    (half_div),
        .shift_done  (sh_done),
        .running     (seq_running),
        .ptr         (seq_ptr),
        .shift_start (seq_start),
        .cs_active   (seq_cs),
        .rx_we       (seq_rx_we),
        .finished    (seq_fin),
        .aborted     (seq_abort)
    );

    qspi_shift #(.W(W), .CW(DIVW)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (seq_start),
        .tx_word  (ram_rd_b[0]),
        .nbits    (nbits),
        .cpol     (r_q.mode[9]),
        .cpha     (r_q.mode[8]),
        .half_div (half_div),
        .miso     (miso),
        .busy     (sh_busy),
        .done     (sh_done),
        .rx_word  (sh_rx),
        .sck      (sck),
        .mosi     (mosi)
    );

    assign cs_out = seq_cs ? ~r_q.qctl[12] : r_q.qctl[12];
    assign irq    = r_q.fin && r_q.ien;

    // R8: an idle queue leaves the select at its inactive level
    a_r8_cs_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !seq_running |-> (cs_out == r_q.qctl[12]));

    // R9 / R10: every end of a run leaves a finish or an abort mark
    a_r10_end_leaves_mark: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(seq_running) |-> (r_q.fin || r_q.abrt));

    // R11: a collision mark only arises during a run
    a_r11_collision_in_run: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.wcol) |-> $past(seq_running));

    // R6: a run starts only with the master enabled
    a_r6_start_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_running) |-> $past(r_q.mode[15]));

    // R3: the serial engine works only inside a run
    a_r3_engine_in_run: assert property (@(posedge clk) disable iff (!rst_n)
        sh_busy |-> seq_running);
endmodule

// File: tb/qspi_queue_master_test.sv
module qspi_queue_master_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_en = 1'b0, reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq, sck, mosi, cs_out;
    logic        miso = 1'b0;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    qspi_queue_master uut (
        .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .sck(sck), .mosi(mosi), .miso(miso), .cs_out(cs_out)
    );

    // serial slave model
    logic        s_cpol = 1'b0, s_cpha = 1'b0, lead;
    int          s_n = 8, s_idx = 0, s_edges = 0, cs_rises = 0;
    logic [15:0] s_words [16];
    logic [15:0] cap     [16];
    logic [15:0] s_sh = '0, s_rx = '0;
    time         s_t1 = 0, s_half = 0;

    always @(negedge cs_out) begin
        s_edges = 0;
        s_rx    = '0;
        s_sh    = s_words[s_idx] << (16 - s_n);
        miso    = s_sh[15];
    end

    always @(posedge cs_out) cs_rises++;

    always @(sck) begin
        if (cs_out == 1'b0) begin
            s_edges++;
            if (s_edges == 1) s_t1 = $time;
            if (s_edges == 2) s_half = $time - s_t1;
            lead = (sck != s_cpol);
            if (lead) begin
                if (!s_cpha) s_rx = {s_rx[14:0], mosi};
                else if (s_edges > 1) begin s_sh = s_sh << 1; miso = s_sh[15]; end
            end else begin
                if (!s_cpha) begin s_sh = s_sh << 1; miso = s_sh[15]; end
                else s_rx = {s_rx[14:0], mosi};
            end
            if (s_edges == 2 * s_n) begin
                cap[s_idx] = s_rx;
                s_idx   = (s_idx + 1) % 16;
                s_edges = 0;
                s_rx    = '0;
                s_sh    = s_words[s_idx] << (16 - s_n);
                miso    = s_sh[15];
            end
        end
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_en = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_en = 1'b0; reg_wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [4:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_en = 1'b1; reg_wr = 1'b0; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_en = 1'b0;
    endtask

    task automatic wait_idle();
        logic [15:0] v;
        int n = 0;
        v = 16'h8000;
        while (v[15] && n < 20000) begin
            bus_rd(5'h04, v);
            n++;
        end
    endtask

    // vector table: mode, command, transmit word, slave word, bits, half period in ns
    localparam int NV = 6;
    localparam logic [15:0] V_MODE [NV] = '{16'h8002, 16'h8203, 16'hB102, 16'hA704, 16'hB101, 16'hBE05};
    localparam logic [15:0] V_CMD  [NV] = '{16'h0000, 16'h4000, 16'h4000, 16'h4000, 16'h0000, 16'h4000};
    localparam logic [15:0] V_TX   [NV] = '{16'h00A5, 16'hBEEF, 16'h0ABC, 16'h01F3, 16'h0F5A, 16'h7FFE};
    localparam logic [15:0] V_SL   [NV] = '{16'h003C, 16'h1234, 16'h0567, 16'h0155, 16'h00C3, 16'h2AAA};
    localparam int          V_N    [NV] = '{8, 16, 12, 9, 8, 15};
    localparam int          V_HALF [NV] = '{8, 12, 8, 16, 8, 20};

    initial begin
        #800000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] v, mask;
        for (int i = 0; i < 16; i++) begin s_words[i] = '0; cap[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        bus_rd(5'h00, v); chk("R1 mode", v, 16'h0000);
        bus_rd(5'h04, v); chk("R1 run", v, 16'h0000);
        bus_rd(5'h08, v); chk("R1 qctl", v, 16'h1000);
        bus_rd(5'h0C, v); chk("R1 status", v, 16'h0000);
        bus_rd(5'h10, v); chk("R1 pointer", v, 16'h0000);
        chk("R1 pins", {13'd0, irq, sck, cs_out}, 16'h0001);

        // R2 indirect access and auto-increment
        bus_wr(5'h10, 16'h0005);
        bus_wr(5'h14, 16'h1234);
        bus_rd(5'h10, v); chk("R2 pointer after write", v, 16'h0006);
        bus_wr(5'h10, 16'h0005);
        bus_rd(5'h14, v); chk("R2 readback", v, 16'h1234);
        bus_rd(5'h10, v); chk("R2 pointer after read", v, 16'h0006);
        bus_wr(5'h10, 16'h0013);
        bus_wr(5'h14, 16'hFFFF);
        bus_wr(5'h10, 16'h0013);
        bus_rd(5'h14, v); chk("R2 receive entry read-only", v, 16'h0000);

        // vector table: one-entry queues in every mode
        for (int i = 0; i < NV; i++) begin
            mask = 16'((32'd1 << V_N[i]) - 1);
            bus_wr(5'h00, V_MODE[i]);
            bus_wr(5'h10, 16'h0020); bus_wr(5'h14, V_CMD[i]);
            bus_wr(5'h10, 16'h0000); bus_wr(5'h14, V_TX[i]);
            bus_wr(5'h08, 16'h1000);
            s_cpol = V_MODE[i][9]; s_cpha = V_MODE[i][8]; s_n = V_N[i];
            s_words[0] = V_SL[i]; s_idx = 0;
            bus_wr(5'h04, 16'h8000);
            wait_idle();
            chk("R4 R5 word seen by slave", cap[0], V_TX[i] & mask);
            bus_wr(5'h10, 16'h0010);
            bus_rd(5'h14, v); chk("R4 R5 received word", v, V_SL[i] & mask);
            chk("R3 half period ns", 16'(s_half), 16'(V_HALF[i]));
            chk("R4 idle clock level", {15'd0, sck}, {15'd0, V_MODE[i][9]});
            bus_wr(5'h0C, 16'h0001);
        end

        // R7 index wrap 14,15,0,1 and R8 select between entries
        bus_wr(5'h00, 16'h8002);
        s_cpol = 1'b0; s_cpha = 1'b0; s_n = 8;
        bus_wr(5'h10, 16'h002E); bus_wr(5'h14, 16'h8000); bus_wr(5'h14, 16'h0000);
        bus_wr(5'h10, 16'h0020); bus_wr(5'h14, 16'h0000); bus_wr(5'h14, 16'h0000);
        bus_wr(5'h10, 16'h000E); bus_wr(5'h14, 16'h0011); bus_wr(5'h14, 16'h0022);
        bus_wr(5'h10, 16'h0000); bus_wr(5'h14, 16'h0033); bus_wr(5'h14, 16'h0044);
        s_words[0] = 16'h00A1; s_words[1] = 16'h00B2; s_words[2] = 16'h00C3; s_words[3] = 16'h00D4;
        s_idx = 0;
        bus_wr(5'h08, 16'h110E);
        cs_rises = 0;
        bus_wr(5'h04, 16'h8000);
        bus_rd(5'h04, v); chk("R6 run bit set", v, 16'h8000);
        wait_idle();
        chk("R7 order entry 14", cap[0], 16'h0011);
        chk("R7 order entry 15", cap[1], 16'h0022);
        chk("R7 order entry 0", cap[2], 16'h0033);
        chk("R7 order entry 1", cap[3], 16'h0044);
        bus_wr(5'h10, 16'h001E);
        bus_rd(5'h14, v); chk("R7 rx entry 14", v, 16'h00A1);
        bus_rd(5'h14, v); chk("R7 rx entry 15", v, 16'h00B2);
        bus_wr(5'h10, 16'h0010);
        bus_rd(5'h14, v); chk("R7 rx entry 0", v, 16'h00C3);
        bus_rd(5'h14, v); chk("R7 rx entry 1", v, 16'h00D4);
        chk("R8 select releases", 16'(cs_rises), 16'd3);

        // R9 finish flag and interrupt
        bus_rd(5'h0C, v); chk("R9 finish flag", v, 16'h0001);
        chk("R9 irq masked", {15'd0, irq}, 16'd0);
        bus_wr(5'h0C, 16'h0100);
        chk("R9 irq enabled", {15'd0, irq}, 16'd1);
        bus_wr(5'h0C, 16'h0101);
        bus_rd(5'h0C, v); chk("R9 flag cleared", v, 16'h0100);
        chk("R9 irq after clear", {15'd0, irq}, 16'd0);
        bus_wr(5'h0C, 16'h0000);

        // R6 start ignored without enable or with divider 0
        bus_wr(5'h00, 16'h0002);
        bus_wr(5'h04, 16'h8000);
        bus_rd(5'h04, v); chk("R6 master off", v, 16'h0000);
        bus_wr(5'h00, 16'h8000);
        bus_wr(5'h04, 16'h8000);
        bus_rd(5'h04, v); chk("R6 divider zero", v, 16'h0000);
        chk("R8 select idle", {15'd0, cs_out}, 16'd1);

        // R7 looping, R11 collision, R10 abort
        bus_wr(5'h00, 16'h8008);
        bus_wr(5'h10, 16'h0020); bus_wr(5'h14, 16'h0000);
        bus_wr(5'h10, 16'h0000); bus_wr(5'h14, 16'h005A);
        bus_wr(5'h08, 16'h5000);
        s_idx = 0;
        bus_wr(5'h04, 16'h8000);
        repeat (400) @(negedge clk);
        bus_rd(5'h04, v); chk("R7 looping queue still running", v, 16'h8000);
        bus_wr(5'h10, 16'h0000);
        bus_wr(5'h14, 16'hFFFF);
        bus_rd(5'h0C, v); chk("R11 collision flag", v, 16'h0008);
        bus_wr(5'h04, 16'h0000);
        wait_idle();
        bus_rd(5'h0C, v); chk("R10 abort flag no finish", v, 16'h000C);
        bus_wr(5'h10, 16'h0000);
        bus_rd(5'h14, v); chk("R11 active entry kept", v, 16'h005A);
        bus_wr(5'h0C, 16'h000C);
        bus_rd(5'h0C, v); chk("R10 R11 flags cleared", v, 16'h0000);

        // R12 halt between entries
        bus_wr(5'h00, 16'h8002);
        bus_wr(5'h10, 16'h0020); bus_wr(5'h14, 16'h0000); bus_wr(5'h14, 16'h0000);
        bus_wr(5'h10, 16'h0000); bus_wr(5'h14, 16'h0066); bus_wr(5'h14, 16'h0077);
        bus_wr(5'h08, 16'h9100);
        s_idx = 0;
        bus_wr(5'h04, 16'h8000);
        repeat (200) @(negedge clk);
        bus_rd(5'h04, v); chk("R12 held run bit", v, 16'h8000);
        chk("R12 one entry while held", 16'(s_idx), 16'd1);
        bus_wr(5'h08, 16'h1100);
        wait_idle();
        chk("R12 resumed entry count", 16'(s_idx), 16'd2);
        chk("R12 second word", cap[1], 16'h0077);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule